// File: doc/BRIEF.md
# Iterative Integer Divider with Truncating and Floored Rounding

This block divides one integer by another over several clock cycles. It returns a quotient and a remainder. Each operand has its own signedness flag. A mode bit picks the rounding of the quotient: toward zero (truncating) or toward negative infinity (floored). Operand magnitudes pass through one unsigned restoring shift-subtract core at one bit per clock. A final correction cycle restores the signs and applies the floored adjustment, so both rounding conventions share the same hardware.

Operands enter through a valid/ready pair. `in_ready` is high only while the unit is idle. A beat is taken when `in_valid` and `in_ready` are both high. While a division runs, `in_ready` stays low and the source must hold its request, because the unit takes nothing in. Results come back with a single-cycle `done` strobe and no back-pressure. The quotient, the remainder and the divide-by-zero flag then stay constant until the next result is delivered.

Top module: `rdiv_unit`

## Requirements
- R1: When idle, `in_ready` is 1. A cycle with `in_valid`=1 and `in_ready`=1 captures `in_a`, `in_b`, both signedness flags and `in_floor`. From then until the result is delivered, `in_ready` is 0, and `in_valid` together with changed operands has no effect on that result.
- R2: `done` is high for exactly one cycle. It starts at the (WIDTH+1)-th rising edge after the accepting edge. WIDTH is the largest of A_W, B_W and Y_W.
- R3: With `in_floor`=0 the quotient is rounded toward zero, and a nonzero remainder has the sign of the dividend.
- R4: With `in_floor`=1 the quotient is rounded toward negative infinity, and a nonzero remainder has the sign of the divisor.
- R5: For a nonzero divisor, in both modes, quotient × divisor + remainder equals the dividend modulo 2^Y_W.
- R6: When both signedness flags are 0, both modes give the same quotient and remainder.
- R7: A flag of 1 sign-extends its operand and a flag of 0 zero-extends it, so a zero-flagged operand with its top bit set is a large positive value. Mixed-signedness pairs are divided exactly on these extended values.
- R8: For a zero divisor, `done` still arrives with `div_by_zero`=1. The quotient is all ones and the remainder is the extended dividend cut to Y_W bits. `div_by_zero` is 0 after any division with a nonzero divisor.
- R9: `quotient`, `remainder` and `div_by_zero` change only in the cycle in which `done` is high.
- R10: After reset `in_ready`=1, `busy`=0, `done`=0, and `quotient`, `remainder` and `div_by_zero` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Unit idle; beat is taken when both are high |
| in_a | input | A_W | Dividend |
| in_b | input | B_W | Divisor |
| in_a_signed | input | 1 | 1: dividend is two's complement |
| in_b_signed | input | 1 | 1: divisor is two's complement |
| in_floor | input | 1 | 0: truncating, 1: floored rounding |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle strobe: results updated |
| quotient | output | Y_W | Quotient, low Y_W bits |
| remainder | output | Y_W | Remainder, low Y_W bits |
| div_by_zero | output | 1 | Last division had a zero divisor |

## Verification
The bench builds the unit with A_W, B_W and Y_W all set to 4. At that size every dividend/divisor pair can be swept under all four signedness combinations and both rounding modes, with expected results computed from integer arithmetic. The sweep reaches the most negative dividend divided by minus one, where the quotient wraps, and every zero divisor. It also covers each case where the floored adjustment fires or stays off. In some runs, new operands are offered while the unit is busy, to show they are refused. The latency of every division is counted as well.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } rdiv_state_e;

  function automatic int max3(input int x, input int y, input int z);
    int m;
    m = (x > y) ? x : y;
    return (m > z) ? m : z;
  endfunction
endpackage

// File: rtl/rdiv_prep.sv
module rdiv_prep #(
  parameter int IN_W = 8,
  parameter int W    = 8,
  parameter int EW   = W + 1
) (
  input  logic [IN_W-1:0] opnd,
  input  logic            is_signed,
  output logic [EW-1:0]   ext,
  output logic [W-1:0]    mag
);
  logic          fill;
  logic [EW-1:0] absv;

  assign fill = is_signed & opnd[IN_W-1];
  assign ext  = {{(EW-IN_W){fill}}, opnd};
  assign absv = ext[EW-1] ? (~ext + 1'b1) : ext;
  assign mag  = absv[W-1:0];
endmodule

// File: rtl/rdiv_core.sv
module rdiv_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo_mag,
  output logic [W-1:0] rem_mag
);
  logic [W-1:0] quo, rem, dv;
  logic [W:0]   trial, diff, qsh;
  logic         q_bit;

  assign trial = {rem, quo[W-1]};
  assign diff  = trial - {1'b0, dv};
  assign q_bit = (trial >= {1'b0, dv});
  assign qsh   = {quo, q_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo <= '0;
      rem <= '0;
      dv  <= '0;
    end else if (load) begin
      quo <= dividend;
      rem <= '0;
      dv  <= divisor;
    end else if (step) begin
      quo <= qsh[W-1:0];
      rem <= q_bit ? diff[W-1:0] : trial[W-1:0];
    end
  end

  assign quo_mag = quo;
  assign rem_mag = rem;

  // R5: partial remainder never reaches the divisor
  p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && dv != '0) |=> (rem < dv));
endmodule

// File: rtl/rdiv_fix.sv
module rdiv_fix #(
  parameter int W   = 8,
  parameter int EW  = W + 1,
  parameter int Y_W = 8
) (
  input  logic [W-1:0]   quo_mag,
  input  logic [W-1:0]   rem_mag,
  input  logic [EW-1:0]  ext_a,
  input  logic [EW-1:0]  ext_b,
  input  logic           floor_m,
  input  logic           zero_div,
  output logic [Y_W-1:0] q,
  output logic [Y_W-1:0] r
);
  logic          neg_a, neg_b, opp, adj;
  logic [EW-1:0] mq, mr, tq, tr, fq, fr;

  assign neg_a = ext_a[EW-1];
  assign neg_b = ext_b[EW-1];
  assign opp   = neg_a ^ neg_b;
  assign mq    = {{(EW-W){1'b0}}, quo_mag};
  assign mr    = {{(EW-W){1'b0}}, rem_mag};
  assign tq    = opp   ? (~mq + 1'b1) : mq;
  assign tr    = neg_a ? (~mr + 1'b1) : mr;
  assign adj   = floor_m & opp & (rem_mag != '0);
  assign fq    = adj ? (tq - 1'b1) : tq;
  assign fr    = adj ? (tr + ext_b) : tr;
  assign q     = zero_div ? '1 : fq[Y_W-1:0];
  assign r     = zero_div ? ext_a[Y_W-1:0] : fr[Y_W-1:0];
endmodule

// File: rtl/rdiv_unit.sv
module rdiv_unit #(
  parameter int A_W = 8,
  parameter int B_W = 8,
  parameter int Y_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [A_W-1:0] in_a,
  input  logic [B_W-1:0] in_b,
  input  logic           in_a_signed,
  input  logic           in_b_signed,
  input  logic           in_floor,
  output logic           busy,
  output logic           done,
  output logic [Y_W-1:0] quotient,
  output logic [Y_W-1:0] remainder,
  output logic           div_by_zero
);
  import rdiv_pkg::*;

  localparam int W  = max3(A_W, B_W, Y_W);
  localparam int EW = W + 1;
  localparam int CW = $clog2(W + 1);

  rdiv_state_e   state;
  logic [CW-1:0] cnt;
  logic [EW-1:0] ext_a_w, ext_b_w, ext_a_r, ext_b_r;
  logic [W-1:0]  mag_a_w, mag_b_w, quo_mag, rem_mag;
  logic [Y_W-1:0] fix_q, fix_r;
  logic          floor_r, accept, zero_div;

  rdiv_prep #(.IN_W(A_W), .W(W), .EW(EW)) u_prep_a (
    .opnd(in_a), .is_signed(in_a_signed), .ext(ext_a_w), .mag(mag_a_w));
  rdiv_prep #(.IN_W(B_W), .W(W), .EW(EW)) u_prep_b (
    .opnd(in_b), .is_signed(in_b_signed), .ext(ext_b_w), .mag(mag_b_w));

  assign in_ready = (state == ST_IDLE);
  assign busy     = ~in_ready;
  assign accept   = in_valid & in_ready;
  assign zero_div = (ext_b_r == '0);

  rdiv_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(state == ST_RUN),
    .dividend(mag_a_w), .divisor(mag_b_w),
    .quo_mag(quo_mag), .rem_mag(rem_mag));

  rdiv_fix #(.W(W), .EW(EW), .Y_W(Y_W)) u_fix (
    .quo_mag(quo_mag), .rem_mag(rem_mag), .ext_a(ext_a_r), .ext_b(ext_b_r),
    .floor_m(floor_r), .zero_div(zero_div), .q(fix_q), .r(fix_r));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      ext_a_r     <= '0;
      ext_b_r     <= '0;
      floor_r     <= 1'b0;
      done        <= 1'b0;
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          ext_a_r <= ext_a_w;
          ext_b_r <= ext_b_w;
          floor_r <= in_floor;
          cnt     <= '0;
          state   <= ST_RUN;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) state <= ST_FIX;
        end
        ST_FIX: begin
          quotient    <= fix_q;
          remainder   <= fix_r;
          div_by_zero <= zero_div;
          done        <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic [Y_W-1:0] id_lhs;
  assign id_lhs = quotient * ext_b_r[Y_W-1:0] + remainder;

  // R2: result strobe lasts one cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: the end of a run always delivers a result
  p_end_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R1: a run starts only from an offered beat
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid));
  // R9: outputs move only together with the strobe
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));
  // R5: division identity on delivered results
  p_identity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> (id_lhs == ext_a_r[Y_W-1:0]));
  // R8: zero divisor gives an all-ones quotient
  p_dbz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_by_zero) |-> (&quotient));
endmodule

// File: tb/sim_rdiv_unit.sv
module sim_rdiv_unit;
  localparam int AW = 4, BW = 4, YW = 4;
  localparam int WID = 4;
  localparam int MASK = (1 << YW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_a_signed = 1'b0, in_b_signed = 1'b0, in_floor = 1'b0;
  logic [AW-1:0] in_a = '0;
  logic [BW-1:0] in_b = '0;
  logic in_ready, busy, done, div_by_zero;
  logic [YW-1:0] quotient, remainder;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rdiv_unit #(.A_W(AW), .B_W(BW), .Y_W(YW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_a_signed(in_a_signed), .in_b_signed(in_b_signed),
    .in_floor(in_floor), .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .div_by_zero(div_by_zero));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int val(input int x, input bit s);
    return (s && x >= 8) ? x - 16 : x;
  endfunction

  task automatic run_div(input int a, input int b, input bit sa, input bit sb,
                         input bit fl, input bit inject);
    int av, bv, tq, tr, eq, er, n;
    bit ez;
    string tag;
    av = val(a, sa);
    bv = val(b, sb);
    if (bv == 0) begin
      eq = MASK; er = av & MASK; ez = 1; tag = "R8";
    end else begin
      tq = av / bv; tr = av % bv; ez = 0;
      if (fl && tr != 0 && ((tr < 0) != (bv < 0))) begin
        tq = tq - 1; tr = tr + bv;
      end
      eq = tq & MASK; er = tr & MASK;
      if (!sa && !sb) tag = "R6";
      else if (sa != sb) tag = "R7";
      else tag = fl ? "R4" : "R3";
    end
    @(negedge clk);
    in_a = a[AW-1:0]; in_b = b[BW-1:0];
    in_a_signed = sa; in_b_signed = sb; in_floor = fl; in_valid = 1'b1;
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    n = 0;
    while (n < 20) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 1 && inject) begin
        in_a = ~a[AW-1:0]; in_b = b[BW-1:0] + 4'd3; in_floor = ~fl; in_valid = 1'b1;
        chk(in_ready == 1'b0, "R1 busy", int'(in_ready), 0);
      end
      if (n == 2) in_valid = 1'b0;
      if (done) break;
    end
    chk(n == WID + 1, "R2 latency", n, WID + 1);
    chk(int'(quotient) == eq, {tag, " quotient"}, int'(quotient), eq);
    chk(int'(remainder) == er, {tag, " remainder"}, int'(remainder), er);
    chk(div_by_zero == ez, "R8 flag", int'(div_by_zero), int'(ez));
    if (inject) chk(int'(quotient) == eq, "R1 ignored", int'(quotient), eq);
  endtask

  initial begin
    int hq, hr, hz;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1 && busy == 1'b0, "R10 ready", int'(in_ready), 1);
    chk(done == 1'b0, "R10 done", int'(done), 0);
    chk(quotient == '0 && remainder == '0 && div_by_zero == 1'b0, "R10 results",
        int'(quotient), 0);
    rst_n = 1'b1;
    for (int m = 0; m < 8; m++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          run_div(a, b, m[0], m[1], m[2], (a == b));
        end
      end
    end
    run_div(9, 3, 1'b1, 1'b1, 1'b1, 1'b0);
    hq = int'(quotient); hr = int'(remainder); hz = int'(div_by_zero);
    repeat (4) @(negedge clk);
    chk(int'(quotient) == hq && int'(remainder) == hr && int'(div_by_zero) == hz,
        "R9 hold", int'(quotient), hq);
    chk(done == 1'b0, "R2 single pulse", int'(done), 0);
    finished = 1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) chk(1'b0, "watchdog", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule